// File: doc/BRIEF.md
# Pending Interrupt Scanner and Two-Level ID Encoder

This block takes one snapshot of the pending-status word for a single output group of an interrupt aggregator. It then reports the set bits one at a time, lowest position first. For each pending line it produces two identifiers:

- an absolute system number: the position inside the group, plus the number of lines owned by all lower groups;
- a packed two-level number: the processor line that the group drives sits in the low byte, and the position plus one sits above it.

There are three groups. Group 0 owns 32 lines and uses parent processor line 19. Groups 1 and 2 own 64 lines each and use parent lines 20 and 21. For example, system line 34 falls in group 1 at position 2 and encodes to 0x314.

A scan begins with a start strobe and the group index. Results leave on a valid/ready stream. A one-cycle done flag closes every scan, including a scan of an empty word.

Top module: `irq_scan_encoder`

## Requirements
- R1: After reset, `out_valid_o` and `done_o` are low.
- R2: Each set bit in the captured word yields exactly one accepted entry, and entries come in increasing bit order.
- R3: `sys_id_o` equals the bit position plus the group base. The base is 0 for group 0, 32 for group 1 and 96 for group 2.
- R4: `enc_id_o[15:8]` equals the bit position plus one. `enc_id_o[7:0]` carries the parent line: 19, 20 or 21 for groups 0, 1 and 2.
- R5: For group 0, only `status_i[31:0]` is scanned and bits 63:32 produce no entry. Every entry's position lies below its group's line count.
- R6: While `out_valid_o` is high and `out_ready_i` is low, the valid flag and both IDs hold their values.
- R7: `done_o` is high for exactly the one cycle that follows the acceptance of the last entry. `out_valid_o` is low in that cycle.
- R8: A start with an all-zero captured word raises `done_o` in the cycle after the start edge and produces no entry.
- R9: The word is sampled on the accepted start edge. Later changes on `status_i` and `master_i` do not alter the entries of that scan.
- R10: A start strobe that arrives while entries are still pending has no effect on the current scan.
- R11: A start with group index 3 is ignored: no entry is produced and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan, sampled while idle |
| master_i | input | 2 | Group index for the scan |
| status_i | input | 64 | Pending-status word of the group |
| out_valid_o | output | 1 | Entry available |
| out_ready_i | input | 1 | Consumer takes the entry |
| sys_id_o | output | 8 | Absolute system line number |
| enc_id_o | output | 16 | Packed two-level identifier |
| done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The hardest case to reach from the ports is a scan that is disturbed in the middle. A new start, a new group index and a changed status word must all arrive while an entry is held under backpressure, and the held entry and every later entry must still come from the original snapshot. The directed tasks stall the consumer for one cycle on each entry. In that stall cycle they pulse start with group 0 and drive the complement of the word, then keep the complement on `status_i` for the rest of the scan. Boundary positions are covered separately: bit 0 of group 0, bit 63 of group 2, and a group 0 word whose upper half is full.

// File: rtl/irq_scan_pkg.sv
package irq_scan_pkg;
    localparam int STATUS_W    = 64;
    localparam int NUM_MASTERS = 3;
    localparam int LOW_LINES   = 32;
    localparam int HIGH_LINES  = 64;
    localparam int PARENT_BASE = 19;
    localparam int LVL1_BITS   = 8;
    localparam int ENC_W       = 16;
    localparam int SYS_W       = 8;
    localparam int LVL2_W      = ENC_W - LVL1_BITS;
    localparam int REL_W       = $clog2(STATUS_W);
    localparam int MIDX_W      = $clog2(NUM_MASTERS + 1);

    typedef struct packed {
        logic                busy;
        logic [STATUS_W-1:0] pend;
        logic [MIDX_W-1:0]   midx;
        logic                done;
    } scan_state_t;

    function automatic int master_lines(input logic [MIDX_W-1:0] m);
        return (m == '0) ? LOW_LINES : HIGH_LINES;
    endfunction

    function automatic int master_base(input logic [MIDX_W-1:0] m);
        return (m == '0) ? 0 : LOW_LINES + (int'(m) - 1) * HIGH_LINES;
    endfunction

    function automatic int parent_line(input logic [MIDX_W-1:0] m);
        return PARENT_BASE + int'(m);
    endfunction

    function automatic logic [STATUS_W-1:0] lines_mask(input logic [MIDX_W-1:0] m);
        logic [STATUS_W-1:0] r;
        int n;
        n = master_lines(m);
        for (int b = 0; b < STATUS_W; b++) r[b] = (b < n);
        return r;
    endfunction
endpackage

// File: rtl/irq_scan_lsb.sv
module irq_scan_lsb #(
    parameter int W   = 64,
    parameter int IDX = $clog2(W)
) (
    input  logic [W-1:0]   vec_i,
    output logic [IDX-1:0] idx_o,
    output logic [W-1:0]   onehot_o
);
    // Isolate the lowest set bit.
    assign onehot_o = vec_i & (~vec_i + W'(1));

    always_comb begin
        idx_o = '0;
        for (int b = W - 1; b >= 0; b--) begin
            if (vec_i[b]) idx_o = IDX'(b);
        end
    end
endmodule

// File: rtl/irq_scan_idgen.sv
module irq_scan_idgen
    import irq_scan_pkg::*;
(
    input  logic [MIDX_W-1:0] midx_i,
    input  logic [REL_W-1:0]  rel_i,
    output logic [SYS_W-1:0]  sys_o,
    output logic [ENC_W-1:0]  enc_o
);
    always_comb begin
        sys_o = SYS_W'(master_base(midx_i) + int'(rel_i));
        enc_o = {LVL2_W'(int'(rel_i) + 1), LVL1_BITS'(parent_line(midx_i))};
    end
endmodule

// File: rtl/irq_scan_encoder.sv
module irq_scan_encoder
    import irq_scan_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [MIDX_W-1:0]   master_i,
    input  logic [STATUS_W-1:0] status_i,
    output logic                out_valid_o,
    input  logic                out_ready_i,
    output logic [SYS_W-1:0]    sys_id_o,
    output logic [ENC_W-1:0]    enc_id_o,
    output logic                done_o
);
    scan_state_t         st_d, st_q;
    logic [REL_W-1:0]    low_idx;
    logic [STATUS_W-1:0] low_onehot;
    logic [STATUS_W-1:0] masked;

    irq_scan_lsb #(.W(STATUS_W), .IDX(REL_W)) u_lsb (
        .vec_i    (st_q.pend),
        .idx_o    (low_idx),
        .onehot_o (low_onehot)
    );

    irq_scan_idgen u_idgen (
        .midx_i (st_q.midx),
        .rel_i  (low_idx),
        .sys_o  (sys_id_o),
        .enc_o  (enc_id_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        masked    = status_i & lines_mask(master_i);
        if (!st_q.busy) begin
            if (start_i && int'(master_i) < NUM_MASTERS) begin
                st_d.midx = master_i;
                st_d.pend = masked;
                st_d.busy = |masked;
                st_d.done = ~|masked;
            end
        end else if (out_ready_i) begin
            st_d.pend = st_q.pend & ~low_onehot;
            if (~|st_d.pend) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.busy;
    assign done_o      = st_q.done;
endmodule

// File: rtl/irq_scan_encoder_chk.sv
module irq_scan_encoder_chk
    import irq_scan_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid_o,
    input logic             out_ready_i,
    input logic [SYS_W-1:0] sys_id_o,
    input logic [ENC_W-1:0] enc_id_o,
    input logic             done_o
);
    logic [MIDX_W-1:0] c_midx;
    int                c_par;
    int                c_rel1;

    always_comb begin
        c_par  = int'(enc_id_o[LVL1_BITS-1:0]);
        c_rel1 = int'(enc_id_o[ENC_W-1:LVL1_BITS]);
        c_midx = MIDX_W'(c_par - PARENT_BASE);
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(sys_id_o) && $stable(enc_id_o));

    p_ascending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i |=> !out_valid_o || (sys_id_o > $past(sys_id_o)));

    p_parent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (c_par >= PARENT_BASE) && (c_par < PARENT_BASE + NUM_MASTERS));

    p_sysid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> int'(sys_id_o) == master_base(c_midx) + c_rel1 - 1);

    p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (c_rel1 >= 1) && (c_rel1 <= master_lines(c_midx)));

    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !out_valid_o);
endmodule

bind irq_scan_encoder irq_scan_encoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .sys_id_o    (sys_id_o),
    .enc_id_o    (enc_id_o),
    .done_o      (done_o)
);

// File: tb/sim_irq_scan_encoder.sv
module sim_irq_scan_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  master_i = '0;
    logic [63:0] status_i = '0;
    logic        out_valid_o;
    logic        out_ready_i = 1'b0;
    logic [7:0]  sys_id_o;
    logic [15:0] enc_id_o;
    logic        done_o;
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_scan_encoder u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .master_i(master_i),
        .status_i(status_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
        .sys_id_o(sys_id_o), .enc_id_o(enc_id_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_base(input int m);
        return (m == 0) ? 0 : (m == 1) ? 32 : 96;
    endfunction

    function automatic int exp_enc(input int m, input int rel);
        return ((rel + 1) << 8) | (19 + m);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic run_scan(input int m, input logic [63:0] st, input bit stall,
                            input bit disturb, input string tag);
        logic [63:0] eff;
        int left;
        eff = (m == 0) ? (st & 64'h0000_0000_FFFF_FFFF) : st;
        left = $countones(eff);
        @(negedge clk);
        start_i = 1'b1; master_i = m[1:0]; status_i = st;
        @(negedge clk);
        start_i = 1'b0;
        if (eff == 64'd0) begin
            chk({tag, " R8 done after empty start"}, int'(done_o), 1);
            chk({tag, " R8 no entry"}, int'(out_valid_o), 0);
            @(negedge clk);
            chk({tag, " R8 done one cycle"}, int'(done_o), 0);
            chk({tag, " R8 still no entry"}, int'(out_valid_o), 0);
            return;
        end
        for (int i = 0; i < 64; i++) begin
            if (eff[i]) begin
                chk({tag, " R2 valid"}, int'(out_valid_o), 1);
                chk({tag, " R3 system id"}, int'(sys_id_o), exp_base(m) + i);
                chk({tag, " R4 encoded id"}, int'(enc_id_o), exp_enc(m, i));
                if (stall) begin
                    out_ready_i = 1'b0;
                    if (disturb) begin
                        start_i = 1'b1; master_i = 2'd0; status_i = ~st;
                    end
                    @(negedge clk);
                    start_i = 1'b0;
                    chk({tag, " R6 R10 hold valid"}, int'(out_valid_o), 1);
                    chk({tag, " R6 R9 hold system id"}, int'(sys_id_o), exp_base(m) + i);
                    chk({tag, " R6 R9 hold encoded id"}, int'(enc_id_o), exp_enc(m, i));
                end
                out_ready_i = 1'b1;
                @(negedge clk);
                out_ready_i = 1'b0;
                left--;
                if (left > 0) chk({tag, " R7 no early done"}, int'(done_o), 0);
            end
        end
        chk({tag, " R7 done after last"}, int'(done_o), 1);
        chk({tag, " R7 R2 no extra entry"}, int'(out_valid_o), 0);
        @(negedge clk);
        chk({tag, " R7 done single cycle"}, int'(done_o), 0);
        status_i = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid after reset", int'(out_valid_o), 0);
        chk("R1 done after reset", int'(done_o), 0);
    endtask

    task automatic t_bad_master();
        @(negedge clk);
        start_i = 1'b1; master_i = 2'd3; status_i = 64'h5;
        @(negedge clk);
        start_i = 1'b0;
        chk("R11 no entry for group 3", int'(out_valid_o), 0);
        chk("R11 no done for group 3", int'(done_o), 0);
        @(negedge clk);
        chk("R11 still idle", int'(out_valid_o), 0);
        status_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_scan(1, 64'h4, 1'b0, 1'b0, "example 34");
        run_scan(0, 64'h1, 1'b0, 1'b0, "group0 bit0");
        run_scan(2, 64'h8000_0000_0000_0001, 1'b1, 1'b0, "group2 edges");
        run_scan(1, 64'h0000_0100_0001_0220, 1'b1, 1'b1, "disturbed scan");
        run_scan(0, 64'hFFFF_FFFF_0000_0009, 1'b0, 1'b0, "R5 group0 upper");
        run_scan(0, 64'hFFFF_0000_0000_0000, 1'b0, 1'b0, "R5 group0 upper only");
        run_scan(2, 64'd0, 1'b0, 1'b0, "empty word");
        t_bad_master();
        run_scan(2, 64'hA5A5_0000_0000_00F0, 1'b1, 1'b1, "after bad group");
        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule